// File: doc/BRIEF.md
# PHY Control Register with Timed Soft Reset

This block holds the control and configuration registers of a 10/100 PHY and carries out the soft reset that is started by software. Writing a one to the top bit of the control register starts a reset window of fixed length. For every cycle of that window the block drives a reset enable to the PHY register bank. A read of the top bit returns one while the window is open, so software can poll it until the reset has finished. When the window closes, the block sends a one-cycle pulse that tells the auto-negotiation logic to start again.

On entry to the window, the control fields go back to their defaults. Configuration bits outside a retain mask also return to their defaults, while bits inside the mask keep their values. The scrambler-disable bit is one of the retained bits. Software can write it at any time, but the value that drives the datapath is loaded only after a soft reset has completed. The management port and the datapath are not reset by this block.

Top module: `phy_softreset_ctl`

## Requirements
- R1: After the synchronous reset `rst`, a read of address 0 returns 0x3000 and a read of address 1 returns 0x0000. `bank_rst`, `an_restart` and `scr_dis` are all 0. Each read request (`rd` high for one cycle) returns `rdata` with `rd_valid` high exactly one cycle later. A hard reset during a window ends the window without an `an_restart` pulse.
- R2: When bit 15 of a write to the control register (address 0) is 0, bits 14, 13, 12 and 8 take the written value. The other bits read as 0, and no soft reset starts.
- R3: A write to address 0 with bit 15 set while no window is open raises `bank_rst` in the next cycle. `bank_rst` then stays high for exactly SR_CYCLES cycles (default 150).
- R4: Bit 15 of a control-register read returns 1 while the window is open and 0 otherwise.
- R5: On entry to the window, the control fields are set to 0x3000 and the other bits of the starting write are discarded. Configuration bits outside CFG_RETAIN (default 0x0011) return to 0, and bits inside it keep their values.
- R6: `scr_dis` follows configuration bit 0 only after a window completes. It changes one cycle after the `an_restart` pulse and never changes during a window.
- R7: `an_restart` is high for exactly one cycle: the first cycle in which `bank_rst` is low after a window.
- R8: Every write that arrives while the window is open is ignored. This includes a second write of bit 15, which does not lengthen the window.
- R9: Addresses 2 and 3 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address (0 control, 1 configuration) |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd` |
| bank_rst | output | 1 | Reset enable to the PHY register bank during the window |
| an_restart | output | 1 | One-cycle pulse when a soft reset completes |
| scr_dis | output | 1 | Scrambler disable value in effect |

## Verification
The bench measures the window length by counting `bank_rst` cycles. It writes bit 15 again late in the window; a design that restarted its counter would report a window longer than 150 cycles. Writes to the control and configuration registers issued inside the window are checked by reading the registers after it, so a design without the write gate would return the written values instead of the defaults. The scrambler-disable bit is changed between resets, and its effective output is checked before and after each completion; a design that passed the bit straight through, or that cleared it on reset, would show the wrong value. A hard reset in the middle of a window must leave no pending restart pulse.

// File: rtl/phy_sr_pkg.sv
package phy_sr_pkg;
  localparam int unsigned CTRL_IDX = 0;
  localparam int unsigned CFG_IDX  = 1;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_NONE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/phy_sr_timer.sv
module phy_sr_timer #(
  parameter int unsigned SR_CYCLES = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = (SR_CYCLES > 2) ? $clog2(SR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        cnt_q <= LOAD;
      end
    end
  end
endmodule

// File: rtl/phy_sr_regs.sv
module phy_sr_regs
  import phy_sr_pkg::*;
#(
  parameter int unsigned REG_W      = 16,
  parameter int unsigned ADDR_W     = 2,
  parameter logic [REG_W-1:0] CTRL_DEF   = 16'h3000,
  parameter logic [REG_W-1:0] CTRL_WMASK = 16'h7100,
  parameter logic [REG_W-1:0] CFG_DEF    = 16'h0000,
  parameter logic [REG_W-1:0] CFG_RETAIN = 16'h0011,
  parameter int unsigned SCR_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  input  logic              done,
  output logic              start,
  output logic [REG_W-2:0]  ctrl_q,
  output logic [REG_W-1:0]  cfg_q,
  output logic              scr_eff
);
  localparam logic [REG_W-2:0] CTRL_RST = CTRL_DEF[REG_W-2:0] & CTRL_WMASK[REG_W-2:0];
  localparam logic [REG_W-2:0] CTRL_MSK = CTRL_WMASK[REG_W-2:0];

  reg_sel_e sel;

  always_comb begin
    if (addr == ADDR_W'(CTRL_IDX))     sel = SEL_CTRL;
    else if (addr == ADDR_W'(CFG_IDX)) sel = SEL_CFG;
    else                               sel = SEL_NONE;
  end

  assign start = wr && (sel == SEL_CTRL) && wdata[REG_W-1] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      cfg_q  <= CFG_DEF;
    end else if (start) begin
      ctrl_q <= CTRL_RST;
      cfg_q  <= (cfg_q & CFG_RETAIN) | (CFG_DEF & ~CFG_RETAIN);
    end else if (wr && !busy) begin
      case (sel)
        SEL_CTRL: ctrl_q <= wdata[REG_W-2:0] & CTRL_MSK;
        SEL_CFG:  cfg_q  <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       scr_eff <= 1'b0;
    else if (done) scr_eff <= cfg_q[SCR_BIT];
  end
endmodule

// File: rtl/phy_sr_rdport.sv
module phy_sr_rdport
  import phy_sr_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-2:0]  ctrl_q,
  input  logic [REG_W-1:0]  cfg_q,
  input  logic              busy,
  output logic [REG_W-1:0]  rdata,
  output logic              rd_valid
);
  logic [REG_W-1:0] mux;

  always_comb begin
    if (addr == ADDR_W'(CTRL_IDX))     mux = {busy, ctrl_q};
    else if (addr == ADDR_W'(CFG_IDX)) mux = cfg_q;
    else                               mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd;
      if (rd) rdata <= mux;
    end
  end
endmodule

// File: rtl/phy_softreset_ctl.sv
module phy_softreset_ctl #(
  parameter int unsigned REG_W      = 16,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned SR_CYCLES  = 150,
  parameter logic [REG_W-1:0] CTRL_DEF   = 16'h3000,
  parameter logic [REG_W-1:0] CTRL_WMASK = 16'h7100,
  parameter logic [REG_W-1:0] CFG_DEF    = 16'h0000,
  parameter logic [REG_W-1:0] CFG_RETAIN = 16'h0011,
  parameter int unsigned SCR_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              rd_valid,
  output logic              bank_rst,
  output logic              an_restart,
  output logic              scr_dis
);
  logic             start;
  logic             busy;
  logic             done;
  logic [REG_W-2:0] ctrl_q;
  logic [REG_W-1:0] cfg_q;

  phy_sr_timer #(.SR_CYCLES(SR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  phy_sr_regs #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .CTRL_DEF(CTRL_DEF), .CTRL_WMASK(CTRL_WMASK),
    .CFG_DEF(CFG_DEF), .CFG_RETAIN(CFG_RETAIN), .SCR_BIT(SCR_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata), .busy(busy),
    .done(done), .start(start), .ctrl_q(ctrl_q), .cfg_q(cfg_q), .scr_eff(scr_dis)
  );

  phy_sr_rdport #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd(rd), .addr(addr), .ctrl_q(ctrl_q), .cfg_q(cfg_q),
    .busy(busy), .rdata(rdata), .rd_valid(rd_valid)
  );

  assign bank_rst   = busy;
  assign an_restart = done;
endmodule

// File: rtl/phy_softreset_chk.sv
module phy_softreset_chk #(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned SR_CYCLES = 150
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic              wdata_msb,
  input logic              rdata_msb,
  input logic              rd_valid,
  input logic              bank_rst,
  input logic              an_restart,
  input logic              scr_dis
);
  localparam int unsigned RUN_W = $clog2(SR_CYCLES + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (bank_rst) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(bank_rst) && !$past(rst)) |-> (run_q == RUN_W'(SR_CYCLES))); // R3

  AST_START_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == '0 && wdata_msb && !bank_rst) |=> bank_rst); // R3

  AST_BUSY_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(addr) == '0) |-> (rdata_msb == $past(bank_rst))); // R4

  AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (rst)
    an_restart |-> ($past(bank_rst) && !bank_rst)); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    an_restart |=> !an_restart); // R7

  AST_SCR_HELD: assert property (@(posedge clk) disable iff (rst)
    (bank_rst && $past(bank_rst)) |-> $stable(scr_dis)); // R6

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd |=> rd_valid); // R1
endmodule

bind phy_softreset_ctl phy_softreset_chk #(.ADDR_W(ADDR_W), .SR_CYCLES(SR_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wr(wr), .rd(rd), .addr(addr), .wdata_msb(wdata[REG_W-1]),
  .rdata_msb(rdata[REG_W-1]), .rd_valid(rd_valid), .bank_rst(bank_rst),
  .an_restart(an_restart), .scr_dis(scr_dis)
);

// File: tb/test_phy_softreset_ctl.sv
module test_phy_softreset_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid, bank_rst, an_restart, scr_dis;

  int checks = 0;
  int errs = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  phy_softreset_ctl i_phy_softreset_ctl (
    .clk(clk), .rst(rst), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .bank_rst(bank_rst),
    .an_restart(an_restart), .scr_dis(scr_dis)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errs++;
        $display("FAIL R1 unexpected rd_valid actual=%0h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic push_read(input logic [1:0] a, input logic [15:0] e, input string tag);
    rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); push_read(a, e, tag);
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // counts window cycles from the negedge after the starting write
  task automatic run_window(output int hi, input bit poke);
    hi = 0;
    while (bank_rst === 1'b1 && hi < 1000) begin
      hi++;
      wr = 1'b0; rd = 1'b0;
      if (poke) begin
        case (hi)
          3:   begin wr = 1'b1; addr = 2'd0; wdata = 16'h4000; end
          4:   begin wr = 1'b1; addr = 2'd1; wdata = 16'h0000; end
          5:   begin wr = 1'b1; addr = 2'd0; wdata = 16'h8000; end
          6:   push_read(2'd0, 16'hB000, "R4 busy bit");
          149: begin wr = 1'b1; addr = 2'd0; wdata = 16'h8000; end
          default: ;
        endcase
      end
      @(negedge clk);
    end
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    int hi;
    int pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 bank_rst", bank_rst, 0);
    check("R1 an_restart", an_restart, 0);
    check("R1 scr_dis", scr_dis, 0);
    rd_reg(2'd0, 16'h3000, "R1 ctrl reset");
    rd_reg(2'd1, 16'h0000, "R1 cfg reset");

    wr_reg(2'd0, 16'h7FFF);
    check("R2 no start on bit15=0", bank_rst, 0);
    rd_reg(2'd0, 16'h7100, "R2 ctrl mask");
    wr_reg(2'd0, 16'h4100);
    rd_reg(2'd0, 16'h4100, "R2 ctrl write");

    wr_reg(2'd2, 16'hFFFF);
    wr_reg(2'd3, 16'hFFFF);
    rd_reg(2'd2, 16'h0000, "R9 addr2");
    rd_reg(2'd3, 16'h0000, "R9 addr3");
    rd_reg(2'd0, 16'h4100, "R9 ctrl untouched");

    wr_reg(2'd1, 16'h00F1);
    rd_reg(2'd1, 16'h00F1, "R6 cfg write");
    check("R6 scr_dis before reset", scr_dis, 0);

    // first soft reset, with writes poked into the window
    wr_reg(2'd0, 16'h8000);
    check("R3 window opens", bank_rst, 1);
    run_window(hi, 1'b1);
    check("R3 R8 window length", hi, 150);
    check("R7 pulse at end", an_restart, 1);
    @(negedge clk);
    check("R7 pulse single", an_restart, 0);
    check("R6 scr_dis loaded", scr_dis, 1);
    rd_reg(2'd0, 16'h3000, "R5 R8 ctrl default");
    rd_reg(2'd1, 16'h0011, "R5 R8 cfg retained");

    // second soft reset: new scrambler value only after completion
    wr_reg(2'd1, 16'h0000);
    check("R6 scr_dis holds", scr_dis, 1);
    wr_reg(2'd0, 16'hF1FF);
    run_window(hi, 1'b0);
    check("R3 second window", hi, 150);
    check("R6 scr_dis before load", scr_dis, 1);
    @(negedge clk);
    check("R6 scr_dis reloaded", scr_dis, 0);
    rd_reg(2'd0, 16'h3000, "R5 discard write bits");

    // hard reset in the middle of a window
    wr_reg(2'd0, 16'h8000);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 window cleared", bank_rst, 0);
    pulses = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (an_restart) pulses++;
    end
    check("R1 no pulse after hard reset", pulses, 0);
    rd_reg(2'd0, 16'h3000, "R1 R4 ctrl after hard reset");

    check("R1 reads drained", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end
endmodule